// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Layer

This block is the network layer of a single-wire bus slave. It sits above a slot decoder that has already turned the analog waveform into clean single-cycle events: a bus reset (with a flag saying whether the low pulse lasted at least 480 µs), a received bit from a master write slot, and a master read slot that consumes one bit from the slave. The block holds a 64-bit registration number and decodes the one-byte ROM command that follows every bus reset. It then carries out the chosen command: reading out the registration number, addressing by full number comparison, taking part in the bitwise search arbitration, skipping addressing, resuming a previous selection, or either of the two overdrive variants.

When a command ends successfully, the block raises a grant to the function layer above it. That grant stays up until the next bus reset. The block also keeps two flags across bus resets. The overdrive flag tells the slot decoder to use fast timing. The resume flag remembers that this slave was the one last singled out by addressing. A slave that loses arbitration, fails a comparison or receives an unknown opcode goes quiet until the next bus reset.

Top module: `onewr_rom_layer`

## Requirements
- R1: After `rst_n` is released, the grant, overdrive and resume outputs are 0 and the line is released. Bit slots are ignored until the first bus reset.
- R2: After a bus reset, the next 8 write slots form the command byte, least significant bit first. The codes are 33h read-out, 55h address match, F0h search, CCh skip, 3Ch overdrive skip, 69h overdrive match and A5h resume.
- R3: Read-out answers 64 read slots with the registration number, least significant bit first. The order is the 8-bit family byte, then the 48-bit serial, then a CRC-8 computed over those 56 bits (polynomial x^8+x^5+x^4+1, register starting at 0, fed LSB first). The grant rises after the 64th slot.
- R4: Address match compares 64 write slots with the registration number. If all 64 agree, the grant and the resume flag are set. On the first disagreement the slave goes quiet with no grant until the next bus reset.
- R5: For each of the 64 search positions, the slave answers one read slot with its bit and a second with the complement, then takes the master's direction bit from a write slot. A direction that differs from its own bit makes it drop out until the next bus reset. Completing all 64 positions sets the grant and the resume flag.
- R6: Skip and overdrive skip raise the grant straight after the command byte, with no number exchange.
- R7: Overdrive skip and overdrive match set the overdrive flag at the end of the command byte. A long bus reset clears the flag; a short bus reset leaves it unchanged.
- R8: Any command byte other than resume clears the resume flag. Resume grants access when the flag is set and sends the slave quiet when it is clear; in both cases the flag keeps its value.
- R9: An unknown command byte sends the slave quiet, with no grant and the line released, until the next bus reset.
- R10: A bus reset aborts any sequence, drops the grant and restarts command reception. It leaves the resume flag unchanged.
- R11: The line output is open-drain. It pulls low only while the slave is answering a read slot with a 0, and it is released during receive phases, while quiet and while granted.
- R12: A slot of the wrong direction for the current phase is ignored. This means a read slot while the slave expects a write slot, or a write slot while it expects a read slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rst_i | input | 1 | One-cycle pulse: bus reset seen |
| bus_rst_long_i | input | 1 | Qualifies `bus_rst_i`: reset pulse was long enough to leave overdrive |
| rx_stb_i | input | 1 | One-cycle pulse: master write slot decoded |
| rx_bit_i | input | 1 | Bit value of that write slot |
| tx_stb_i | input | 1 | One-cycle pulse: master read slot taken |
| tx_pull_low_o | output | 1 | Pull the line low in the current read slot |
| fn_grant_o | output | 1 | Function layer may take over the bus |
| od_mode_o | output | 1 | Overdrive timing in force |
| resume_o | output | 1 | Resume flag |

## Verification
The hardest situation to reach from the ports is a slave that has dropped out of a search or match part-way through. It must then stay silent for every remaining slot, yet keep its resume and overdrive flags intact for the next bus reset. The bench reaches this by flipping one randomly chosen bit among the 64, then running the rest of the sequence to the end and checking that every later read slot sees a released line. It mixes these runs with random good and bad sequences, while a bench model tracks the resume flag. Slots of the wrong direction are inserted in the middle of match and read-out sequences to show that they have no effect.

// File: rtl/onewr_pkg.sv
package onewr_pkg;

  localparam logic [7:0] OP_READ     = 8'h33;
  localparam logic [7:0] OP_MATCH    = 8'h55;
  localparam logic [7:0] OP_SEARCH   = 8'hF0;
  localparam logic [7:0] OP_SKIP     = 8'hCC;
  localparam logic [7:0] OP_OD_SKIP  = 8'h3C;
  localparam logic [7:0] OP_OD_MATCH = 8'h69;
  localparam logic [7:0] OP_RESUME   = 8'hA5;

  typedef enum logic [2:0] {
    CK_READ, CK_MATCH, CK_SEARCH, CK_SKIP,
    CK_OD_SKIP, CK_OD_MATCH, CK_RESUME, CK_BAD
  } cmd_kind_e;

  typedef enum logic [2:0] {
    ST_QUIET, ST_CMD, ST_READ, ST_MATCH,
    ST_SRCH_BIT, ST_SRCH_CMP, ST_SRCH_DIR, ST_GRANT
  } rom_st_e;

  // One step of the 8-stage CRC shift register, x^8+x^5+x^4+1.
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
    logic fb;
    logic [7:0] n;
    fb   = c[0] ^ b;
    n[7] = fb;
    n[6] = c[7];
    n[5] = c[6];
    n[4] = c[5];
    n[3] = c[4] ^ fb;
    n[2] = c[3] ^ fb;
    n[1] = c[2];
    n[0] = c[1];
    return n;
  endfunction

  function automatic logic is_overdrive(input cmd_kind_e k);
    return (k == CK_OD_SKIP) || (k == CK_OD_MATCH);
  endfunction

endpackage

// File: rtl/onewr_rom_image.sv
module onewr_rom_image #(
  parameter int FAM_W = 8,
  parameter int SER_W = 48,
  parameter logic [FAM_W-1:0] FAMILY_CODE = '0,
  parameter logic [SER_W-1:0] SERIAL_NUM  = '0,
  localparam int BODY_W = FAM_W + SER_W,
  localparam int ID_W   = BODY_W + 8,
  localparam int IW     = $clog2(ID_W)
) (
  input  logic [IW-1:0] idx_i,
  output logic          bit_o
);

  function automatic logic [7:0] crc_over(input logic [BODY_W-1:0] body);
    logic [7:0] c;
    c = 8'h00;
    for (int i = 0; i < BODY_W; i++) c = onewr_pkg::crc8_step(c, body[i]);
    return c;
  endfunction

  localparam logic [BODY_W-1:0] BODY  = {SERIAL_NUM, FAMILY_CODE};
  localparam logic [ID_W-1:0]   IMAGE = {crc_over(BODY), BODY};

  assign bit_o = IMAGE[idx_i];

endmodule

// File: rtl/onewr_cmd_decode.sv
module onewr_cmd_decode
  import onewr_pkg::*;
(
  input  logic [7:0] code_i,
  output cmd_kind_e  kind_o
);

  always_comb begin
    unique case (code_i)
      OP_READ:     kind_o = CK_READ;
      OP_MATCH:    kind_o = CK_MATCH;
      OP_SEARCH:   kind_o = CK_SEARCH;
      OP_SKIP:     kind_o = CK_SKIP;
      OP_OD_SKIP:  kind_o = CK_OD_SKIP;
      OP_OD_MATCH: kind_o = CK_OD_MATCH;
      OP_RESUME:   kind_o = CK_RESUME;
      default:     kind_o = CK_BAD;
    endcase
  end

endmodule

// File: rtl/onewr_mode_flags.sv
module onewr_mode_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic od_set_i,
  input  logic od_clr_i,
  input  logic rc_set_i,
  input  logic rc_clr_i,
  output logic od_o,
  output logic rc_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_o <= 1'b0;
      rc_o <= 1'b0;
    end else begin
      if (od_clr_i)      od_o <= 1'b0;
      else if (od_set_i) od_o <= 1'b1;
      if (rc_set_i)      rc_o <= 1'b1;
      else if (rc_clr_i) rc_o <= 1'b0;
    end
  end

endmodule

// File: rtl/onewr_rom_layer.sv
module onewr_rom_layer
  import onewr_pkg::*;
#(
  parameter int FAM_W = 8,
  parameter int SER_W = 48,
  parameter logic [FAM_W-1:0] FAMILY_CODE = 8'hB3,
  parameter logic [SER_W-1:0] SERIAL_NUM  = 48'h0000_5A3C_91E7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rst_i,
  input  logic bus_rst_long_i,
  input  logic rx_stb_i,
  input  logic rx_bit_i,
  input  logic tx_stb_i,
  output logic tx_pull_low_o,
  output logic fn_grant_o,
  output logic od_mode_o,
  output logic resume_o
);

  localparam int ID_W  = FAM_W + SER_W + 8;
  localparam int IW    = $clog2(ID_W);
  localparam int CMD_W = 8;

  rom_st_e          st_q, st_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [CMD_W-2:0] cmd_sr_q, cmd_sr_d;

  // Named internal events (also observed by the checker).
  logic       ev_rx, ev_tx;
  logic       last_id_bit, last_cmd_bit;
  logic       ev_cmd_done;
  logic       ev_seq_fail, ev_seq_win, ev_read_done;
  logic       my_bit, dir_agrees;
  logic [7:0] cmd_byte;
  cmd_kind_e  cmd_kind;

  assign ev_rx        = rx_stb_i & ~bus_rst_i;
  assign ev_tx        = tx_stb_i & ~bus_rst_i;
  assign last_id_bit  = (idx_q == IW'(ID_W - 1));
  assign last_cmd_bit = (idx_q == IW'(CMD_W - 1));
  assign cmd_byte     = {rx_bit_i, cmd_sr_q};
  assign ev_cmd_done  = ev_rx && (st_q == ST_CMD) && last_cmd_bit;
  assign dir_agrees   = (rx_bit_i == my_bit);
  assign ev_seq_fail  = ev_rx && ((st_q == ST_MATCH) || (st_q == ST_SRCH_DIR)) && !dir_agrees;
  assign ev_seq_win   = ev_rx && ((st_q == ST_MATCH) || (st_q == ST_SRCH_DIR)) && dir_agrees && last_id_bit;
  assign ev_read_done = ev_tx && (st_q == ST_READ) && last_id_bit;

  onewr_rom_image #(
    .FAM_W(FAM_W), .SER_W(SER_W),
    .FAMILY_CODE(FAMILY_CODE), .SERIAL_NUM(SERIAL_NUM)
  ) u_image (
    .idx_i(idx_q),
    .bit_o(my_bit)
  );

  onewr_cmd_decode u_decode (
    .code_i(cmd_byte),
    .kind_o(cmd_kind)
  );

  onewr_mode_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .od_set_i(ev_cmd_done && is_overdrive(cmd_kind)),
    .od_clr_i(bus_rst_i && bus_rst_long_i),
    .rc_set_i(ev_seq_win),
    .rc_clr_i(ev_cmd_done && (cmd_kind != CK_RESUME)),
    .od_o    (od_mode_o),
    .rc_o    (resume_o)
  );

  // Where a decoded command leads.
  function automatic rom_st_e dispatch(input cmd_kind_e k, input logic rc);
    case (k)
      CK_READ:                 return ST_READ;
      CK_MATCH, CK_OD_MATCH:   return ST_MATCH;
      CK_SEARCH:               return ST_SRCH_BIT;
      CK_SKIP, CK_OD_SKIP:     return ST_GRANT;
      CK_RESUME:               return rc ? ST_GRANT : ST_QUIET;
      default:                 return ST_QUIET;
    endcase
  endfunction

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    cmd_sr_d = cmd_sr_q;
    if (bus_rst_i) begin
      st_d  = ST_CMD;
      idx_d = '0;
    end else begin
      unique case (st_q)
        ST_CMD: if (ev_rx) begin
          cmd_sr_d = {rx_bit_i, cmd_sr_q[CMD_W-2:1]};
          if (last_cmd_bit) begin
            st_d  = dispatch(cmd_kind, resume_o);
            idx_d = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        ST_READ: if (ev_tx) begin
          if (last_id_bit) st_d = ST_GRANT;
          else             idx_d = idx_q + 1'b1;
        end
        ST_MATCH: if (ev_rx) begin
          if (!dir_agrees)      st_d = ST_QUIET;
          else if (last_id_bit) st_d = ST_GRANT;
          else                  idx_d = idx_q + 1'b1;
        end
        ST_SRCH_BIT: if (ev_tx) st_d = ST_SRCH_CMP;
        ST_SRCH_CMP: if (ev_tx) st_d = ST_SRCH_DIR;
        ST_SRCH_DIR: if (ev_rx) begin
          if (!dir_agrees) begin
            st_d = ST_QUIET;
          end else if (last_id_bit) begin
            st_d = ST_GRANT;
          end else begin
            st_d  = ST_SRCH_BIT;
            idx_d = idx_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_QUIET;
      idx_q    <= '0;
      cmd_sr_q <= '0;
    end else begin
      st_q     <= st_d;
      idx_q    <= idx_d;
      cmd_sr_q <= cmd_sr_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_READ, ST_SRCH_BIT: tx_pull_low_o = ~my_bit;
      ST_SRCH_CMP:          tx_pull_low_o = my_bit;
      default:              tx_pull_low_o = 1'b0;
    endcase
  end

  assign fn_grant_o = (st_q == ST_GRANT);

endmodule

// File: rtl/onewr_rom_layer_chk.sv
module onewr_rom_layer_chk
  import onewr_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      bus_rst_i,
  input logic      bus_rst_long_i,
  input logic      tx_pull_low_o,
  input logic      fn_grant_o,
  input logic      od_mode_o,
  input logic      resume_o,
  input logic      ev_cmd_done,
  input cmd_kind_e cmd_kind,
  input logic      ev_seq_fail,
  input logic      ev_seq_win
);

  a_r7_long_reset_clears_od: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i && bus_rst_long_i |=> !od_mode_o);

  a_r7_short_reset_keeps_od: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i && !bus_rst_long_i |=> $stable(od_mode_o));

  a_r7_od_command_sets_od: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_done && is_overdrive(cmd_kind) |=> od_mode_o);

  a_r10_reset_drops_grant: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> !fn_grant_o);

  a_r10_reset_keeps_resume: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> $stable(resume_o));

  a_r6_grant_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fn_grant_o && !bus_rst_i |=> fn_grant_o);

  a_r11_released_when_granted: assert property (@(posedge clk) disable iff (!rst_n)
    fn_grant_o |-> !tx_pull_low_o);

  a_r4_fail_goes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seq_fail |=> !fn_grant_o && !tx_pull_low_o);

  a_r5_win_grants: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seq_win |=> fn_grant_o && resume_o);

  a_r8_other_cmd_clears_resume: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_done && (cmd_kind != CK_RESUME) |=> !resume_o);

  a_r9_bad_cmd_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_done && (cmd_kind == CK_BAD) |=> !fn_grant_o);

endmodule

bind onewr_rom_layer onewr_rom_layer_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_rst_i     (bus_rst_i),
  .bus_rst_long_i(bus_rst_long_i),
  .tx_pull_low_o (tx_pull_low_o),
  .fn_grant_o    (fn_grant_o),
  .od_mode_o     (od_mode_o),
  .resume_o      (resume_o),
  .ev_cmd_done   (ev_cmd_done),
  .cmd_kind      (cmd_kind),
  .ev_seq_fail   (ev_seq_fail),
  .ev_seq_win    (ev_seq_win)
);

// File: tb/onewr_rom_layer_bench.sv
module onewr_rom_layer_bench;

  localparam logic [7:0]  FAM = 8'hB3;
  localparam logic [47:0] SER = 48'h0000_5A3C_91E7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rst = 1'b0, bus_long = 1'b0;
  logic rx_stb = 1'b0, rx_bit = 1'b0, tx_stb = 1'b0;
  logic tx_pull_low, fn_grant, od_mode, resume;

  int n_chk = 0;
  int n_fail = 0;
  logic exp_rc = 1'b0;
  logic exp_od = 1'b0;

  always #2.5 clk = ~clk;

  onewr_rom_layer #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER)) u_onewr_rom_layer (
    .clk(clk), .rst_n(rst_n),
    .bus_rst_i(bus_rst), .bus_rst_long_i(bus_long),
    .rx_stb_i(rx_stb), .rx_bit_i(rx_bit), .tx_stb_i(tx_stb),
    .tx_pull_low_o(tx_pull_low), .fn_grant_o(fn_grant),
    .od_mode_o(od_mode), .resume_o(resume)
  );

  // Reflected-form CRC-8 (0x8C), restated independently.
  function automatic logic [7:0] ref_crc(input logic [55:0] body);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic f;
      f = c[0] ^ body[i];
      c = c >> 1;
      if (f) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  logic [63:0] ID;
  initial ID = {ref_crc({SER, FAM}), SER, FAM};

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_reset(input logic lng);
    @(negedge clk); bus_rst = 1'b1; bus_long = lng;
    @(negedge clk); bus_rst = 1'b0; bus_long = 1'b0;
    if (lng) exp_od = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx_stb = 1'b1; rx_bit = b;
    @(negedge clk); rx_stb = 1'b0;
  endtask

  task automatic read_bit(output logic b);
    @(negedge clk); b = ~tx_pull_low; tx_stb = 1'b1;
    @(negedge clk); tx_stb = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic check_flags(input string req, input logic g);
    chk(fn_grant == g, req, fn_grant, g);
    chk(resume == exp_rc, req, resume, exp_rc);
    chk(od_mode == exp_od, req, od_mode, exp_od);
    chk(tx_pull_low == 1'b0, req, tx_pull_low, 0);
  endtask

  // Address match; flip < 0 means all bits sent correctly.
  task automatic run_match(input logic [7:0] op, input int flip, input logic wrong_slots);
    logic r;
    bus_reset(1'b0);
    send_byte(op);
    exp_rc = 1'b0;
    if (op == 8'h69) exp_od = 1'b1;
    for (int i = 0; i < 64; i++) begin
      if (wrong_slots && (i % 16 == 5)) begin
        read_bit(r);  // R12: read slot in a receive phase is ignored
        chk(r == 1'b1, "R12 read slot during match", r, 1);
      end
      send_bit(ID[i] ^ (i == flip));
    end
    if (flip < 0) exp_rc = 1'b1;
    check_flags(flip < 0 ? "R4 match success" : "R4 match mismatch", flip < 0);
    if (flip >= 0) begin
      read_bit(r);
      chk(r == 1'b1, "R11 quiet after mismatch", r, 1);
    end
  endtask

  task automatic run_search(input int flip);
    logic b, cb;
    bus_reset(1'b0);
    send_byte(8'hF0);
    exp_rc = 1'b0;
    for (int i = 0; i < 64; i++) begin
      read_bit(b);
      read_bit(cb);
      if (flip < 0 || i <= flip) begin
        chk(b == ID[i], "R5 search bit", b, ID[i]);
        chk(cb == ~ID[i], "R5 search complement", cb, ~ID[i]);
      end else begin
        chk({b, cb} == 2'b11, "R5 dropped slave released", {b, cb}, 2'b11);
      end
      send_bit(ID[i] ^ (i == flip));
    end
    if (flip < 0) exp_rc = 1'b1;
    check_flags(flip < 0 ? "R5 search win" : "R5 search drop", flip < 0);
  endtask

  task automatic run_read(input logic wrong_slots);
    logic [63:0] got;
    logic b;
    bus_reset(1'b0);
    send_byte(8'h33);
    exp_rc = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (wrong_slots && (i % 8 == 3)) send_bit(1'($urandom_range(0, 1)));  // R12
      chk(fn_grant == 1'b0, "R3 no grant during read-out", fn_grant, 0);
      read_bit(b);
      got[i] = b;
    end
    chk(got == ID, "R3 registration number read-out", got, ID);
    check_flags("R3 grant after read-out", 1'b1);
  endtask

  task automatic run_skip(input logic [7:0] op);
    bus_reset(1'b0);
    send_byte(op);
    exp_rc = 1'b0;
    if (op == 8'h3C) exp_od = 1'b1;
    check_flags("R6 skip grant", 1'b1);
  endtask

  task automatic run_resume();
    logic r;
    logic had;
    had = exp_rc;
    bus_reset(1'b0);
    send_byte(8'hA5);
    check_flags("R8 resume", had);
    if (!had) begin
      read_bit(r);
      chk(r == 1'b1, "R8 quiet resume releases line", r, 1);
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic r;
    logic [7:0] bad;
    void'($urandom(32'h0001_5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, slots ignored before first bus reset
    check_flags("R1 reset state", 1'b0);
    send_byte(8'hCC);
    check_flags("R1 slots ignored before bus reset", 1'b0);

    // R2/R6 skip, R3 read-out
    run_skip(8'hCC);
    run_read(1'b0);
    run_read(1'b1);

    // R4 match, R8 resume
    run_match(8'h55, -1, 1'b1);
    run_resume();
    run_resume();
    run_skip(8'hCC);
    run_resume();

    // R5 search
    run_search(-1);
    run_search(0);
    run_search(63);
    run_match(8'h55, 63, 1'b0);

    // R7 overdrive
    run_skip(8'h3C);
    bus_reset(1'b0);
    chk(od_mode == 1'b1, "R7 short reset keeps overdrive", od_mode, 1);
    bus_reset(1'b1);
    chk(od_mode == 1'b0, "R7 long reset clears overdrive", od_mode, 0);
    run_match(8'h69, -1, 1'b0);
    bus_reset(1'b1);
    chk(od_mode == 1'b0, "R7 long reset after overdrive match", od_mode, 0);

    // R10 abort mid-sequence, resume kept across reset
    run_match(8'h55, -1, 1'b0);
    bus_reset(1'b0);
    send_byte(8'h55);
    for (int i = 0; i < 20; i++) send_bit(ID[i]);
    exp_rc = 1'b0;
    bus_reset(1'b0);
    check_flags("R10 abort restores command reception", 1'b0);
    send_byte(8'hCC);
    check_flags("R10 skip after abort", 1'b1);
    run_search(-1);
    bus_reset(1'b0);
    chk(resume == 1'b1, "R10 reset keeps resume", resume, 1);
    chk(fn_grant == 1'b0, "R10 reset drops grant", fn_grant, 0);

    // R9 unknown opcode
    for (int k = 0; k < 4; k++) begin
      do bad = 8'($urandom_range(0, 255));
      while (bad inside {8'h33, 8'h55, 8'hF0, 8'hCC, 8'h3C, 8'h69, 8'hA5});
      bus_reset(1'b0);
      send_byte(bad);
      exp_rc = 1'b0;
      check_flags("R9 unknown opcode quiet", 1'b0);
      read_bit(r);
      chk(r == 1'b1, "R9 unknown opcode line released", r, 1);
      send_byte(8'hCC);
      check_flags("R9 stays quiet until reset", 1'b0);
    end

    // Random mix
    for (int n = 0; n < 24; n++) begin
      case ($urandom_range(0, 6))
        0: run_match(8'h55, $urandom_range(0, 1) ? -1 : int'($urandom_range(0, 63)), 1'($urandom_range(0, 1)));
        1: run_search($urandom_range(0, 1) ? -1 : int'($urandom_range(0, 63)));
        2: run_read(1'($urandom_range(0, 1)));
        3: run_skip($urandom_range(0, 1) ? 8'hCC : 8'h3C);
        4: run_resume();
        5: begin
          bus_reset(1'($urandom_range(0, 1)));
          chk(od_mode == exp_od, "R7 random reset length", od_mode, exp_od);
        end
        default: run_match(8'h69, $urandom_range(0, 1) ? -1 : int'($urandom_range(0, 63)), 1'b0);
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule